// File: doc/BRIEF.md
# Delay-Slot Branch Sequencer

This block steers the program counter of a pipeline whose instruction set has exactly one branch-delay slot and two conditional branch forms. An ordinary delayed branch always lets the instruction after it execute. A cancelling branch is predicted taken: its slot instruction executes only when the branch is taken, and is turned into a no-op when it is not. Each cycle the decode stage presents the instruction at `pc_now` together with its decoded branch kind, its resolved outcome, its target and any exception it raises. The block answers with commit and nullify strobes for that instruction and advances its pair of program counters.

The block keeps two program counters: `pc_now` for the instruction in decode and `pc_next` for the one after it. These two values are what an exception saves. When the trapping instruction sits in the slot of a taken branch, its address and its successor are not sequential. The saved pair then makes the restart exact: the slot instruction runs again, and the next one fetched comes from the saved second address. After an exception the sequencer halts until `resume`, then reloads both counters from the saved pair. A branch found in an executing slot is illegal; it traps instead of branching.

States: `ST_RUN` (ordinary instruction), `ST_SLOT` (executing delay slot), `ST_NULL` (cancelled delay slot), `ST_HALT` (trapped, waiting). Transitions: RUN→SLOT on a delayed branch or a taken cancelling branch; RUN→NULL on an untaken cancelling branch; RUN→HALT and SLOT→HALT on an exception or an illegal branch; SLOT→RUN and NULL→RUN after the slot; HALT→RUN or HALT→SLOT on `resume`, chosen by whether the trapped instruction was a slot.

Top module: `bdc_ctrl`

## Requirements
- R1: After reset `pc_now` is RESET_PC (default 0x0100), `pc_next` is RESET_PC+4, the state is ordinary, and `commit_en`, `nullify`, `illegal_br`, `halted` are all 0.
- R2: Kind code 2'b01 is a delayed branch. Its slot instruction at `pc_next` commits. The instruction after the slot is the target if taken, or the slot address plus 4 if not. Codes 2'b00 and 2'b11 are not branches.
- R3: Kind code 2'b10 is a cancelling branch. When it is taken, its slot instruction commits, and the target follows.
- R4: When a cancelling branch is untaken, its slot instruction has `nullify`=1 and `commit_en`=0, and the slot address plus 4 follows.
- R5: A cancelled slot instruction never traps and is never flagged illegal, whatever exception or branch kind it presents.
- R6: A branch kind (2'b01 or 2'b10) in an executing slot sets `illegal_br`, does not commit, and traps. The saved pair is the slot address and the address that would have followed the slot.
- R7: An exception on an executing slot instruction suppresses its commit. It saves `epc0`=slot address, `epc1`=the address that was to follow it, and `epc_slot`=1.
- R8: While `halted` is 1, nothing commits and the program counters and saved pair hold, whatever `dec_valid` shows; `resume` is the only way out.
- R9: `resume` while halted loads `pc_now`←`epc0` and `pc_next`←`epc1`. The instruction run first after it is treated as a slot exactly when `epc_slot` is 1, so a branch there is illegal.
- R10: With `dec_valid` low outside the halt state, nothing commits and both program counters hold.
- R11: An exception on an ordinary instruction saves `epc0`=its address, `epc1`=its address plus 4, and `epc_slot`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction at `pc_now` is presented this cycle |
| dec_kind | input | 2 | Branch kind: 00 none, 01 delayed, 10 cancelling, 11 none |
| dec_taken | input | 1 | Resolved branch outcome |
| dec_target | input | AW | Branch target address |
| dec_trap | input | 1 | The presented instruction raises an exception |
| resume | input | 1 | Leave the halt state and restart from the saved pair |
| pc_now | output | AW | Address of the instruction in decode |
| pc_next | output | AW | Address of the instruction after it (fetch address) |
| commit_en | output | 1 | The presented instruction completes; its writes may go ahead |
| nullify | output | 1 | The presented instruction is a cancelled slot; all its writes are suppressed |
| illegal_br | output | 1 | A branch was found in an executing slot |
| trap_now | output | 1 | The presented instruction traps this cycle |
| halted | output | 1 | Sequencer is waiting for `resume` |
| epc0 | output | AW | Saved restart address of the trapped instruction |
| epc1 | output | AW | Saved address to follow it |
| epc_slot | output | 1 | The trapped instruction was an executing delay slot |

## Verification
The checker assumes a decode stage that presents, in each valid cycle, the instruction at the address `pc_now` shows, and that drives `resume` only as a reply to `halted`. Targets are taken to be word aligned. The stimulus keeps to these rules: a reference model walks the same two-counter path, and every sequence drives the instruction the model expects. It sweeps every kind code, outcome and slot content (plain, branch, exception), with stalls and halts interleaved. The ordered commit addresses are compared cycle by cycle.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

    typedef enum logic [1:0] {
        BK_NONE   = 2'b00,
        BK_DELAY  = 2'b01,
        BK_CANCEL = 2'b10,
        BK_RSVD   = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SLOT = 2'd1,
        ST_NULL = 2'd2,
        ST_HALT = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/bdc_fsm.sv
module bdc_fsm
    import bdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec_valid,
    input  logic [1:0] dec_kind,
    input  logic       dec_taken,
    input  logic       dec_trap,
    input  logic       resume,
    input  logic       saved_slot,
    output ctl_state_e state,
    output logic       commit,
    output logic       cancel,
    output logic       illegal,
    output logic       take_trap,
    output logic       advance,
    output logic       redirect,
    output logic       restore
);

    ctl_state_e nxt;
    logic       is_branch;

    assign is_branch = (dec_kind == BK_DELAY) || (dec_kind == BK_CANCEL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        commit    = 1'b0;
        cancel    = 1'b0;
        illegal   = 1'b0;
        take_trap = 1'b0;
        advance   = 1'b0;
        redirect  = 1'b0;
        restore   = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (dec_valid) begin
                    if (dec_trap) begin
                        take_trap = 1'b1;
                        nxt       = ST_HALT;
                    end else begin
                        commit  = 1'b1;
                        advance = 1'b1;
                        if (is_branch) begin
                            redirect = dec_taken;
                            nxt = (dec_kind == BK_CANCEL && !dec_taken) ? ST_NULL : ST_SLOT;
                        end
                    end
                end
            end
            ST_SLOT: begin
                if (dec_valid) begin
                    if (dec_trap || is_branch) begin
                        illegal   = is_branch;
                        take_trap = 1'b1;
                        nxt       = ST_HALT;
                    end else begin
                        commit  = 1'b1;
                        advance = 1'b1;
                        nxt     = ST_RUN;
                    end
                end
            end
            ST_NULL: begin
                if (dec_valid) begin
                    cancel  = 1'b1;
                    advance = 1'b1;
                    nxt     = ST_RUN;
                end
            end
            ST_HALT: begin
                if (resume) begin
                    restore = 1'b1;
                    nxt     = saved_slot ? ST_SLOT : ST_RUN;
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

endmodule

// File: rtl/bdc_pc_pair.sv
module bdc_pc_pair #(
    parameter int              AW       = 16,
    parameter int              ALIGN    = 2,
    parameter logic [AW-1:0]   RESET_PC = 16'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          redirect,
    input  logic [AW-1:0] target,
    input  logic          restore,
    input  logic [AW-1:0] back0,
    input  logic [AW-1:0] back1,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] npc
);

    localparam logic [AW-1:0] INC = AW'(1) << ALIGN;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= RESET_PC;
            npc <= RESET_PC + INC;
        end else if (restore) begin
            pc  <= back0;
            npc <= back1;
        end else if (advance) begin
            pc  <= npc;
            npc <= redirect ? target : npc + INC;
        end
    end

endmodule

// File: rtl/bdc_epc.sv
module bdc_epc #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          in_slot,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] npc,
    output logic [AW-1:0] epc0,
    output logic [AW-1:0] epc1,
    output logic          eslot
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc0  <= '0;
            epc1  <= '0;
            eslot <= 1'b0;
        end else if (capture) begin
            epc0  <= pc;
            epc1  <= npc;
            eslot <= in_slot;
        end
    end

endmodule

// File: rtl/bdc_ctrl.sv
module bdc_ctrl
    import bdc_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            ALIGN    = 2,
    parameter logic [AW-1:0] RESET_PC = 16'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [1:0]    dec_kind,
    input  logic          dec_taken,
    input  logic [AW-1:0] dec_target,
    input  logic          dec_trap,
    input  logic          resume,
    output logic [AW-1:0] pc_now,
    output logic [AW-1:0] pc_next,
    output logic          commit_en,
    output logic          nullify,
    output logic          illegal_br,
    output logic          trap_now,
    output logic          halted,
    output logic [AW-1:0] epc0,
    output logic [AW-1:0] epc1,
    output logic          epc_slot
);

    ctl_state_e state;
    logic advance, redirect, restore;

    bdc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_valid  (dec_valid),
        .dec_kind   (dec_kind),
        .dec_taken  (dec_taken),
        .dec_trap   (dec_trap),
        .resume     (resume),
        .saved_slot (epc_slot),
        .state      (state),
        .commit     (commit_en),
        .cancel     (nullify),
        .illegal    (illegal_br),
        .take_trap  (trap_now),
        .advance    (advance),
        .redirect   (redirect),
        .restore    (restore)
    );

    bdc_pc_pair #(.AW(AW), .ALIGN(ALIGN), .RESET_PC(RESET_PC)) u_pcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .redirect (redirect),
        .target   (dec_target),
        .restore  (restore),
        .back0    (epc0),
        .back1    (epc1),
        .pc       (pc_now),
        .npc      (pc_next)
    );

    bdc_epc #(.AW(AW)) u_epc (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (trap_now),
        .in_slot (state == ST_SLOT),
        .pc      (pc_now),
        .npc     (pc_next),
        .epc0    (epc0),
        .epc1    (epc1),
        .eslot   (epc_slot)
    );

    assign halted = (state == ST_HALT);

endmodule

// File: rtl/bdc_ctrl_chk.sv
module bdc_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dec_valid,
    input logic          resume,
    input logic [AW-1:0] pc_now,
    input logic [AW-1:0] pc_next,
    input logic          commit_en,
    input logic          nullify,
    input logic          illegal_br,
    input logic          trap_now,
    input logic          halted,
    input logic [AW-1:0] epc0,
    input logic [AW-1:0] epc1
);

    // R4
    null_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nullify |-> !commit_en);

    // R5
    null_no_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nullify |-> (!illegal_br && !trap_now));

    // R6
    illegal_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_br |-> (trap_now && !commit_en));

    // R2
    pc_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !halted && !trap_now) |=> (pc_now == $past(pc_next)));

    // R7
    trap_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_now |=> (halted && epc0 == $past(pc_now) && epc1 == $past(pc_next)));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !resume) |=> (halted && $stable(pc_now) && $stable(epc0) && $stable(epc1)));

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!commit_en && !nullify && !trap_now));

    // R9
    resume_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && resume) |=> (!halted && pc_now == $past(epc0) && pc_next == $past(epc1)));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_valid && !halted) |=> ($stable(pc_now) && $stable(pc_next)));

endmodule

bind bdc_ctrl bdc_ctrl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .resume     (resume),
    .pc_now     (pc_now),
    .pc_next    (pc_next),
    .commit_en  (commit_en),
    .nullify    (nullify),
    .illegal_br (illegal_br),
    .trap_now   (trap_now),
    .halted     (halted),
    .epc0       (epc0),
    .epc1       (epc1)
);

// File: tb/test_bdc_ctrl.sv
module test_bdc_ctrl;

    localparam int          AW  = 16;
    localparam logic [15:0] RPC = 16'h0100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_valid = 1'b0;
    logic [1:0]    dec_kind = 2'b00;
    logic          dec_taken = 1'b0;
    logic [AW-1:0] dec_target = '0;
    logic          dec_trap = 1'b0;
    logic          resume = 1'b0;
    logic [AW-1:0] pc_now, pc_next, epc0, epc1;
    logic          commit_en, nullify, illegal_br, trap_now, halted, epc_slot;

    int checks = 0;
    int errors = 0;

    // model: 0 ordinary, 1 executing slot, 2 cancelled slot, 3 halted
    int          m_st;
    logic [15:0] m_pc, m_npc, m_e0, m_e1;
    logic        m_es;

    always #4 clk = ~clk;

    bdc_ctrl #(.AW(AW), .ALIGN(2), .RESET_PC(RPC)) i_bdc_ctrl (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
        .dec_taken(dec_taken), .dec_target(dec_target), .dec_trap(dec_trap),
        .resume(resume), .pc_now(pc_now), .pc_next(pc_next), .commit_en(commit_en),
        .nullify(nullify), .illegal_br(illegal_br), .trap_now(trap_now),
        .halted(halted), .epc0(epc0), .epc1(epc1), .epc_slot(epc_slot)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [1:0] k, input bit tk,
                        input logic [15:0] tg, input bit tr, input bit rs, input string tag);
        bit br, e_commit, e_null, e_ill, e_trap;
        @(negedge clk);
        dec_valid = v; dec_kind = k; dec_taken = tk; dec_target = tg;
        dec_trap = tr; resume = rs;
        #1;
        br = (k == 2'b01) || (k == 2'b10);
        e_commit = 0; e_null = 0; e_ill = 0; e_trap = 0;
        if (v && m_st == 0) begin e_trap = tr; e_commit = !tr; end
        if (v && m_st == 1) begin e_ill = br; e_trap = tr || br; e_commit = !(tr || br); end
        if (v && m_st == 2) e_null = 1;
        chk(pc_now == m_pc, tag, "pc_now", pc_now, m_pc);
        chk(pc_next == m_npc, tag, "pc_next", pc_next, m_npc);
        chk(commit_en == e_commit, tag, "commit_en", commit_en, e_commit);
        chk(nullify == e_null, tag, "nullify", nullify, e_null);
        chk(illegal_br == e_ill, tag, "illegal_br", illegal_br, e_ill);
        chk(halted == (m_st == 3), tag, "halted", halted, m_st == 3);
        if (m_st == 3) begin
            chk(epc0 == m_e0, tag, "epc0", epc0, m_e0);
            chk(epc1 == m_e1, tag, "epc1", epc1, m_e1);
            chk(epc_slot == m_es, tag, "epc_slot", epc_slot, m_es);
        end
        @(posedge clk);
        if (m_st == 3) begin
            if (rs) begin m_pc = m_e0; m_npc = m_e1; m_st = m_es ? 1 : 0; end
        end else if (v) begin
            if (e_trap) begin
                m_e0 = m_pc; m_e1 = m_npc; m_es = (m_st == 1); m_st = 3;
            end else if (m_st == 0 && br) begin
                m_pc = m_npc; m_npc = tk ? tg : m_npc + 16'd4;
                m_st = (k == 2'b10 && !tk) ? 2 : 1;
            end else begin
                m_pc = m_npc; m_npc = m_npc + 16'd4; m_st = 0;
            end
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_st = 0; m_pc = RPC; m_npc = RPC + 16'd4; m_e0 = '0; m_e1 = '0; m_es = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(pc_now == RPC, "R1", "pc_now", pc_now, RPC);
        chk(pc_next == RPC + 16'd4, "R1", "pc_next", pc_next, RPC + 16'd4);
        chk(!commit_en && !nullify && !illegal_br && !halted, "R1", "strobes",
            {commit_en, nullify, illegal_br, halted}, 0);

        for (int k = 0; k < 4; k++) begin
            for (int tk = 0; tk < 2; tk++) begin
                for (int so = 0; so < 3; so++) begin
                    logic [15:0] tg;
                    string tag, stag;
                    bit cancelled;
                    tg = 16'h1000 + 16'((k * 6 + tk * 3 + so) * 64);
                    cancelled = (k == 2) && (tk == 0);
                    tag = (k == 2) ? (tk ? "R3" : "R4") : "R2";
                    stag = cancelled ? "R5" : (so == 1 ? "R6" : (so == 2 ? "R7" : tag));
                    step(1, 2'b00, 0, 16'h0, 0, 0, "R2");
                    step(0, 2'b01, 1, 16'h2220, 1, 0, "R10");
                    step(1, 2'(k), tk[0], tg, 0, 0, tag);
                    step(1, (so == 1) ? 2'b01 : 2'b00, 1, 16'h3330, so == 2, 0, stag);
                    step(1, 2'b00, 0, 16'h0, 0, 0, "R8");
                    step(0, 2'b00, 0, 16'h0, 0, 1, "R9");
                    step(1, 2'b00, 0, 16'h0, 0, 0, tag);
                    step(1, 2'b00, 0, 16'h0, 1, 0, "R11");
                    step(1, 2'b00, 0, 16'h0, 0, 0, "R8");
                    step(1, 2'b00, 0, 16'h0, 0, 1, "R9");
                    step(1, 2'b00, 0, 16'h0, 0, 0, "R11");
                end
            end
        end

        // R9 replayed slot still counts as a slot: a branch there is illegal
        step(1, 2'b10, 1, 16'h4400, 0, 0, "R3");
        step(1, 2'b00, 0, 16'h0, 1, 0, "R7");
        step(1, 2'b00, 0, 16'h0, 0, 1, "R9");
        step(1, 2'b01, 1, 16'h5500, 0, 0, "R9");
        step(1, 2'b00, 0, 16'h0, 0, 1, "R6");
        step(1, 2'b00, 0, 16'h0, 0, 0, "R6");
        step(1, 2'b00, 0, 16'h0, 0, 0, "R2");
        // R5 cancelled slot carrying a branch and an exception is ignored
        step(1, 2'b10, 0, 16'h6600, 0, 0, "R4");
        step(1, 2'b10, 1, 16'h7700, 1, 0, "R5");
        step(1, 2'b00, 0, 16'h0, 0, 0, "R5");
        step(1, 2'b00, 0, 16'h0, 0, 0, "R5");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule